// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire station management bus of external Ethernet PHYs. Software writes one 32-bit command word to start a frame. The word carries a start flag, the operation, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block builds the whole management frame, divides the system clock down to MDC, shifts the frame out on MDIO and, on reads, releases the line and samples the PHY's reply.

Software learns that a frame has finished by polling a busy flag in a status register. After a read it fetches the PHY's 16-bit value from a data register. Two flag bits above that value report that the PHY did not answer. A write needs nothing after the command except the wait for busy to clear. The register port is a plain single-cycle write strobe with a combinational read mux. It has no back-pressure: a command written while a frame is in flight is dropped, so software must check busy first.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After a synchronous reset, or a reset during a frame, busy is clear, MDC is low, MDIO is released (`mdio_oe` low) and the status, command and data registers all read 0.
- R2: A write to offset 0x8 with bit 31 set and bits 2:1 equal to 01 (write) or 10 (read), made while idle, sets status bit 3 (busy) from the next cycle. Busy stays set for exactly 128*HALF_DIV clock cycles.
- R3: A command write made while busy, with bit 31 clear, or with bits 2:1 equal to 00 or 11 starts no frame and leaves the command readback unchanged.
- R4: The frame is sent MSB first, in this order: 32 ones, start bits 01, the opcode (10 for read, 01 for write), the PHY address from command bits 29:25 and the register address from bits 24:20. A write then sends turnaround 10 and the data from command bits 19:4.
- R5: MDC is low while idle. Its period is 2*HALF_DIV clocks, and its first low half begins at the accepting edge. MDIO output changes only where MDC falls, apart from the first bit, which is driven at the start of the frame.
- R6: On a read, `mdio_oe` drops for the two turnaround bits and the 16 data bits. `mdio_i` is sampled at the clock edge where MDC rises.
- R7: When a read completes, the data register at offset 0xC holds the sampled bits in 15:0 (first received bit in bit 15), with bits 17:16 zero if the PHY drove the second turnaround bit low. It updates in the cycle busy clears.
- R8: If the second turnaround bit is sampled high, bits 17:16 of the data register are both set.
- R9: A write frame leaves the data register unchanged.
- R10: Status reads at 0x0 (busy at bit 3, all other bits 0) and the command register reads back the last accepted command word at 0x8. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench aims at the turnaround handling. A master that kept driving during turnaround, or that sampled a bit late, would return data shifted by one position or miss a PHY that does not answer. The bench also writes a command in the middle of a frame: a master that accepted it would corrupt the frame it is sending and change the command readback. Opcodes 00 and 11 are offered as well, and a design that decoded a single bit would start a frame on them. A reset in the middle of a frame checks that MDIO is released at once and does not stay driven.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_FIRST   = 46;
  localparam int TA_SECOND  = 47;
  localparam int DATA_FIRST = 48;

  localparam int CMD_GO_BIT  = 31;
  localparam int CMD_PHY_LSB = 25;
  localparam int CMD_REG_LSB = 20;
  localparam int CMD_WD_LSB  = 4;
  localparam int CMD_OP_LSB  = 1;
  localparam int STAT_BUSY_BIT = 3;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_BAD   = 2'b11
  } mdio_op_e;

  typedef struct packed {
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
    mdio_op_e    op;
  } mdio_cmd_t;

  function automatic mdio_cmd_t unpack_cmd(input logic [31:0] w);
    mdio_cmd_t c;
    c.phy   = w[CMD_PHY_LSB +: 5];
    c.regad = w[CMD_REG_LSB +: 5];
    c.wdata = w[CMD_WD_LSB +: 16];
    c.op    = mdio_op_e'(w[CMD_OP_LSB +: 2]);
    return c;
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
    logic [1:0]  ta;
    logic [15:0] payload;
    ta      = (c.op == OP_READ) ? 2'b11 : 2'b10;
    payload = (c.op == OP_READ) ? 16'hFFFF : c.wdata;
    return {{PRE_BITS{1'b1}}, 2'b01, c.op, c.phy, c.regad, ta, payload};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          mdc_q;
  logic          wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = run && wrap && !mdc_q;
  assign fall_tick = run && wrap && mdc_q;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] start_frame,
  input  logic                  start_read,
  input  logic                  rise_tick,
  input  logic                  fall_tick,
  input  logic                  mdio_i,
  output logic                  active,
  output logic                  rd_done,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic [15:0]           rd_val,
  output logic                  rd_err
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_TA1  = IDX_W'(TA_FIRST);
  localparam logic [IDX_W-1:0] IDX_TA2  = IDX_W'(TA_SECOND);
  localparam logic [IDX_W-1:0] IDX_DAT  = IDX_W'(DATA_FIRST);

  logic                  active_q;
  logic                  read_q;
  logic [IDX_W-1:0]      idx;
  logic [FRAME_BITS-1:0] shreg;
  logic [15:0]           cap;
  logic                  err_q;
  logic                  last_bit;

  assign last_bit = (idx == IDX_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      read_q   <= 1'b0;
      idx      <= '0;
      shreg    <= '0;
      cap      <= '0;
      err_q    <= 1'b0;
    end else if (!active_q) begin
      if (start) begin
        active_q <= 1'b1;
        read_q   <= start_read;
        idx      <= '0;
        shreg    <= start_frame;
        cap      <= '0;
        err_q    <= 1'b0;
      end
    end else begin
      if (rise_tick && read_q) begin
        if (idx == IDX_TA2) err_q <= mdio_i;
        else if (idx >= IDX_DAT) cap <= {cap[14:0], mdio_i};
      end
      if (fall_tick) begin
        if (last_bit) begin
          active_q <= 1'b0;
        end else begin
          idx   <= idx + 1'b1;
          shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign active  = active_q;
  assign rd_done = active_q && read_q && fall_tick && last_bit;
  assign mdio_oe = active_q && (!read_q || (idx < IDX_TA1));
  assign mdio_o  = mdio_oe ? shreg[FRAME_BITS-1] : 1'b0;
  assign rd_val  = cap;
  assign rd_err  = err_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int OFF_STATUS = 0,
  parameter int OFF_CMD = 8,
  parameter int OFF_DATA = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [15:0]       rd_val,
  input  logic              rd_err,
  output logic              start,
  output mdio_cmd_t         start_cmd,
  output logic [31:0]       rdata,
  output logic [31:0]       cmd_view,
  output logic [31:0]       data_view
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);

  logic [31:0] cmd_q;
  logic [31:0] data_q;
  logic        op_ok;

  assign start_cmd = unpack_cmd(wdata);
  assign op_ok = (start_cmd.op == OP_WRITE) || (start_cmd.op == OP_READ);
  assign start = wr_en && (addr == A_CMD) && wdata[CMD_GO_BIT] && op_ok && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (start) cmd_q <= wdata;
      if (rd_done) data_q <= {14'd0, rd_err, rd_err, rd_val};
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_STAT)      rdata[STAT_BUSY_BIT] = busy;
    else if (addr == A_CMD)  rdata = cmd_q;
    else if (addr == A_DATA) rdata = data_q;
  end

  assign cmd_view  = cmd_q;
  assign data_view = data_q;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic        busy;
  logic        start;
  mdio_cmd_t   start_cmd;
  logic        rise_tick;
  logic        fall_tick;
  logic        rd_done;
  logic [15:0] rd_val;
  logic        rd_err;
  logic [31:0] cmd_view;
  logic [31:0] data_view;

  mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .rd_done(rd_done), .rd_val(rd_val), .rd_err(rd_err),
    .start(start), .start_cmd(start_cmd), .rdata(reg_rdata),
    .cmd_view(cmd_view), .data_view(data_view)
  );

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
    .clk(clk), .rst(rst), .run(busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst(rst),
    .start(start), .start_frame(build_frame(start_cmd)),
    .start_read(start_cmd.op == OP_READ),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .active(busy), .rd_done(rd_done),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_val(rd_val), .rd_err(rd_err)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        reg_wr_en,
  input logic [31:0] cmd_view,
  input logic [31:0] data_view
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdio_oe && !mdc)) else $error("idle bus not quiet"); // R5

  AST_CMD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr_en) |=> $stable(cmd_view)) else $error("command taken while busy"); // R3

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc)) else $error("MDIO moved off falling edge"); // R5

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(data_view)) else $error("data changed mid-frame"); // R7

  AST_PREAMBLE_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (mdio_oe && mdio_o)) else $error("frame did not open with a one"); // R4
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .reg_wr_en(reg_wr_en),
  .cmd_view(cmd_view), .data_view(data_view)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  localparam int H  = 2;
  localparam int FR = 128 * H;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural reference state
  bit          m_busy = 1'b0;
  bit          m_read = 1'b0;
  bit          m_err  = 1'b0;
  int          m_j = 0;
  int          b = 0;
  logic [31:0] m_cmd = '0;
  logic [31:0] m_data = '0;
  logic [15:0] m_rd = '0;
  logic [63:0] m_frame = '0;
  logic [15:0] phy_val = 16'h0;
  bit          ta_ok = 1'b1;

  mdio_mgmt_master #(.HALF_DIV(H), .ADDR_W(4)) u_mdio_mgmt_master (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] frame_of(input logic [31:0] w);
    logic [1:0]  op;
    logic [15:0] pay;
    op  = w[2:1];
    pay = (op == 2'b10) ? 16'hFFFF : w[19:4];
    return {32'hFFFF_FFFF, 2'b01, op, w[29:25], w[24:20],
            (op == 2'b10) ? 2'b11 : 2'b10, pay};
  endfunction

  // reference model update
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_busy = 0; m_j = 0; m_cmd = '0; m_data = '0;
    end else if (m_busy) begin
      if (m_read && (m_j % (2*H)) == H-1) begin
        b = m_j / (2*H);
        if (b == 47) m_err = (mdio_i !== 1'b0);
        else if (b >= 48) m_rd[63-b] = mdio_i;
      end
      m_j++;
      if (m_j == FR) begin
        m_busy = 0;
        if (m_read) m_data = {14'd0, m_err, m_err, m_rd};
      end
    end else if (reg_wr_en && reg_addr == 4'h8 && reg_wdata[31] &&
                 (reg_wdata[2:1] == 2'b01 || reg_wdata[2:1] == 2'b10)) begin
      m_busy = 1; m_j = 0; m_cmd = reg_wdata;
      m_read = (reg_wdata[2:1] == 2'b10);
      m_err = 0; m_rd = '0; m_frame = frame_of(reg_wdata);
    end
  end

  // per-clock comparison and PHY response
  always @(negedge clk) begin
    int bi;
    logic [31:0] exp_rd;
    bi = m_j / (2*H);
    if (!rst) begin
      check("R5 mdc", {31'd0, mdc}, {31'd0, m_busy && ((m_j / H) % 2 == 1)});
      check("R6 mdio_oe", {31'd0, mdio_oe}, {31'd0, m_busy && (!m_read || bi < 46)});
      if (mdio_oe && m_busy) check("R4 mdio_o", {31'd0, mdio_o}, {31'd0, m_frame[63-bi]});
      exp_rd = 32'h0;
      if (reg_addr == 4'h0) exp_rd[3] = m_busy;
      else if (reg_addr == 4'h8) exp_rd = m_cmd;
      else if (reg_addr == 4'hC) exp_rd = m_data;
      check("R10 reg_rdata", reg_rdata, exp_rd);
    end
    if (m_busy && m_read && bi == 47) mdio_i <= ta_ok ? 1'b0 : 1'b1;
    else if (m_busy && m_read && bi >= 48) mdio_i <= phy_val[63-bi];
    else mdio_i <= 1'b1;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr_en = 1'b0; reg_addr = 4'h0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    reg_addr = a;
    @(negedge clk); #2;
    d = reg_rdata;
    reg_addr = 4'h0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < FR + 20 && m_busy; k++) @(negedge clk);
    #2;
  endtask

  function automatic logic [31:0] mkcmd(input bit go, input logic [1:0] op,
      input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
    return {go, 1'b0, phy, ra, wd, 1'b0, op, 1'b0};
  endfunction

  initial begin
    logic [31:0] v;
    logic [31:0] c_rd;
    int nbusy;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    rd(4'h0, v); check("R1 status after reset", v, 32'h0);
    rd(4'h8, v); check("R1 cmd after reset", v, 32'h0);
    rd(4'hC, v); check("R1 data after reset", v, 32'h0);
    check("R1 mdio released", {31'd0, mdio_oe}, 32'd0);

    // R2 busy length, R6/R7 read result
    phy_val = 16'hA5C3; ta_ok = 1;
    c_rd = mkcmd(1, 2'b10, 5'd5, 5'd3, 16'h0);
    wr(4'h8, c_rd);
    nbusy = 0;
    for (int k = 0; k < FR + 10; k++) begin
      #2; if (reg_rdata[3]) nbusy++;
      @(negedge clk);
    end
    check("R2 busy cycles", nbusy, FR);
    rd(4'hC, v); check("R7 read data", v, 32'h0000_A5C3);
    rd(4'h8, v); check("R10 cmd readback", v, c_rd);

    // R9 write leaves data; R4 frame compared each clock
    wr(4'h8, mkcmd(1, 2'b01, 5'h1F, 5'h11, 16'h1234));
    rd(4'h0, v); check("R2 busy set", v, 32'h8);
    wait_idle();
    rd(4'hC, v); check("R9 data kept after write", v, 32'h0000_A5C3);

    // R3 command while busy
    phy_val = 16'h0F0F;
    c_rd = mkcmd(1, 2'b10, 5'd9, 5'd1, 16'h0);
    wr(4'h8, c_rd);
    repeat (40) @(negedge clk);
    wr(4'h8, mkcmd(1, 2'b01, 5'd2, 5'd2, 16'hBEEF));
    rd(4'h8, v); check("R3 cmd ignored while busy", v, c_rd);
    wait_idle();
    rd(4'hC, v); check("R7 read after ignored cmd", v, 32'h0000_0F0F);

    // R8 missing turnaround
    ta_ok = 0; phy_val = 16'hFFFF;
    wr(4'h8, mkcmd(1, 2'b10, 5'd7, 5'd0, 16'h0));
    wait_idle();
    rd(4'hC, v); check("R8 error flags", v, 32'h0003_FFFF);
    ta_ok = 1;

    // R3 invalid commands
    c_rd = m_cmd;
    wr(4'h8, mkcmd(1, 2'b00, 5'd1, 5'd1, 16'h1));
    rd(4'h0, v); check("R3 op 00 no start", v, 32'h0);
    wr(4'h8, mkcmd(1, 2'b11, 5'd1, 5'd1, 16'h1));
    rd(4'h0, v); check("R3 op 11 no start", v, 32'h0);
    wr(4'h8, mkcmd(0, 2'b10, 5'd1, 5'd1, 16'h1));
    rd(4'h0, v); check("R3 no go bit", v, 32'h0);
    rd(4'h8, v); check("R3 cmd unchanged", v, c_rd);

    // R10 unmapped offset
    rd(4'h4, v); check("R10 unmapped reads zero", v, 32'h0);

    // R1 reset mid-frame
    wr(4'h8, mkcmd(1, 2'b01, 5'd3, 5'd4, 16'h5555));
    repeat (30) @(negedge clk);
    #1 rst = 1'b1;
    repeat (2) @(negedge clk);
    #1 rst = 1'b0;
    #1;
    check("R1 released after reset", {30'd0, mdio_oe, mdc}, 32'd0);
    rd(4'h0, v); check("R1 idle after reset", v, 32'h0);
    rd(4'hC, v); check("R1 data cleared", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule